// File: doc/BRIEF.md
# Block Register Store Sequencer

This block is a micro-sequencer that writes a selected set of general-purpose registers to consecutive memory words, one word per cycle at most. A start pulse hands it a base address, the number of the base register, a 16-bit selection mask, two addressing-mode bits and a writeback enable. For each selected register the block names that register on a read-index port. The register file answers in the same cycle, and the block presents the value as a 32-bit memory write with a valid/ready handshake.

Registers are always written in rising register-number order to rising addresses. Only the lowest address depends on the mode. When the last word is accepted, the block pulses `done`. With the pulse it gives the new base-register value and a qualifier that says whether that value should be written back. The caller does the decoding. For the compact 16-bit instruction form it passes a mask limited to registers 0 to 7 and a base index below 8, with writeback always enabled. The block reads no condition flags and changes none.

Top module: `blkstore_seq`

## Requirements
- R1: Selected registers are written in ascending register number, and each register is written to a higher address than every lower-numbered register.
- R2: Each selected register produces exactly one 32-bit write, and each write's address is 4 above the previous write's address.
- R3: With n = number of set mask bits, the first write address is base when pre_step=0 and step_up=1 (increment-after). It is base+4 when pre_step=1 and step_up=1 (increment-before), base-4n+4 when pre_step=0 and step_up=0 (decrement-after), and base-4n when pre_step=1 and step_up=0 (decrement-before).
- R4: The `done` pulse carries `wb_value` = base+4n when step_up=1 and base-4n when step_up=0, and `wb_idx` = the base register number. `wb_valid` is high with `done` exactly when wb_en was 1 at start.
- R5: If wb_en=1, the base register is in the mask and it is not the lowest set bit, the block writes 0 in that register's slot. `undef_flag` is high for exactly the one cycle in which that write is accepted. In every other case, including when the base is the lowest set bit, the block writes the register's real value.
- R6: Mask bit 15 is written after all of bits 0 to 14, at the highest address of the transfer.
- R7: While mem_valid=1 and mem_ready=0, the address and read index hold. A write counts only on a cycle with both high.
- R8: An all-zero mask produces no write, and `done` rises the cycle after start with `wb_value` equal to the unchanged base.
- R9: A start pulse while `busy`=1 is ignored. The running transfer and its result are unchanged.
- R10: After reset, busy, mem_valid, done, wb_valid and undef_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| base_addr | input | 32 | Current value of the base register |
| base_idx | input | 4 | Number of the base register |
| reg_mask | input | 16 | Bit i selects register i |
| pre_step | input | 1 | 1: step before each store, 0: after |
| step_up | input | 1 | 1: ascending addresses, 0: descending |
| wb_en | input | 1 | Request base writeback |
| rf_idx | output | 4 | Register-file read index |
| rf_data | input | 32 | Register-file read data, same cycle |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 32 | Word address of the write |
| mem_wdata | output | 32 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Writeback requested, with done |
| wb_idx | output | 4 | Register to update |
| wb_value | output | 32 | New base value |
| undef_flag | output | 1 | Zero substituted for the base register |

## Verification
The bench goes after sparse masks with gaps, a full mask including bit 15, and each of the four modes. A wrong start offset would shift every address by one word. A wrong count would place the decrement window away from the base. A mis-ordered walk would swap data between slots. It covers the base register stored as the lowest set bit, stored later with writeback, and stored later without writeback. A design that confused these cases would zero a valid value or leak a stale one. Random back-pressure catches an address that moves during a stall. A start pulse in mid-transfer catches a design that reloads its mask, and the empty mask catches one that hangs or issues a spurious write.

// File: rtl/blkstore_seq.sv
module blkstore_seq #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   base_addr,
  input  logic [IW-1:0]   base_idx,
  input  logic [NREG-1:0] reg_mask,
  input  logic            pre_step,
  input  logic            step_up,
  input  logic            wb_en,
  output logic [IW-1:0]   rf_idx,
  input  logic [DW-1:0]   rf_data,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            busy,
  output logic            done,
  output logic            wb_valid,
  output logic [IW-1:0]   wb_idx,
  output logic [AW-1:0]   wb_value,
  output logic            undef_flag
);
  localparam int STEP = DW / 8;

  function automatic logic [IW-1:0] low_bit(input logic [NREG-1:0] m);
    low_bit = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (m[i]) low_bit = IW'(i);
  endfunction

  logic            run_q, done_q, wb_q;
  logic [NREG-1:0] left_q;
  logic [AW-1:0]   addr_q, wbv_q;
  logic [IW-1:0]   bidx_q, first_q;

  logic [AW-1:0]   span, lo_addr, wb_next;
  logic [IW-1:0]   cur;
  logic [NREG-1:0] left_nxt;
  logic            hazard, xfer;

  assign span    = AW'($countones(reg_mask)) * AW'(STEP);
  assign lo_addr = step_up ? (pre_step ? base_addr + AW'(STEP) : base_addr)
                           : (base_addr - span + (pre_step ? '0 : AW'(STEP)));
  assign wb_next = step_up ? base_addr + span : base_addr - span;

  assign cur      = low_bit(left_q);
  assign left_nxt = left_q & ~(NREG'(1) << cur);
  assign hazard   = wb_q && (cur == bidx_q) && (cur != first_q);
  assign xfer     = run_q && mem_ready;

  assign rf_idx     = cur;
  assign mem_valid  = run_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = hazard ? '0 : rf_data;
  assign undef_flag = xfer && hazard;
  assign busy       = run_q;
  assign done       = done_q;
  assign wb_valid   = done_q && wb_q;
  assign wb_idx     = bidx_q;
  assign wb_value   = wbv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      wb_q    <= 1'b0;
      left_q  <= '0;
      addr_q  <= '0;
      wbv_q   <= '0;
      bidx_q  <= '0;
      first_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (start) begin
          left_q  <= reg_mask;
          addr_q  <= lo_addr;
          wbv_q   <= wb_next;
          bidx_q  <= base_idx;
          first_q <= low_bit(reg_mask);
          wb_q    <= wb_en;
          if (reg_mask == '0) done_q <= 1'b1;
          else                run_q  <= 1'b1;
        end
      end else if (xfer) begin
        left_q <= left_nxt;
        addr_q <= addr_q + AW'(STEP);
        if (left_nxt == '0) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/blkstore_seq_chk.sv
module blkstore_seq_chk #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          wb_valid,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [IW-1:0] rf_idx,
  input logic          undef_flag
);
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (!mem_valid || mem_addr == $past(mem_addr) + AW'(DW / 8)));

  a_r1_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (!mem_valid || rf_idx > $past(rf_idx)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(rf_idx)));

  a_r5_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    undef_flag |-> (mem_valid && mem_ready && mem_wdata == '0));

  a_r4_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_valid));

  a_r9_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(mem_valid && mem_ready)) |=> busy);

  a_r10_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);
endmodule

bind blkstore_seq blkstore_seq_chk #(.AW(AW), .DW(DW), .NREG(NREG)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .wb_valid(wb_valid),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .rf_idx(rf_idx), .undef_flag(undef_flag)
);

// File: tb/blkstore_seq_tb.sv
module blkstore_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [3:0]  base_idx = '0;
  logic [15:0] reg_mask = '0;
  logic        pre_step = 1'b0, step_up = 1'b1, wb_en = 1'b0;
  logic [3:0]  rf_idx;
  logic [31:0] rf_data;
  logic        mem_valid, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic        busy, done, wb_valid, undef_flag;
  logic [3:0]  wb_idx;
  logic [31:0] wb_value;

  int checks = 0, fails = 0;
  logic [31:0] rf [16];

  always #2.5 clk = ~clk;
  assign rf_data = rf[rf_idx];

  blkstore_seq dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] m, input logic [31:0] b, input logic [3:0] bi,
                        input logic pre, input logic up, input logic wb, input bit poke);
    int q_idx[$];
    int n = 0, lowest = -1, guard = 0;
    logic [31:0] a, expwb;
    for (int i = 0; i < 16; i++)
      if (m[i]) begin
        q_idx.push_back(i);
        n++;
        if (lowest < 0) lowest = i;
      end
    if (up) a = pre ? b + 4 : b;
    else    a = b - 32'(4 * n) + (pre ? 32'd0 : 32'd4);
    expwb = up ? b + 32'(4 * n) : b - 32'(4 * n);
    @(negedge clk);
    start = 1'b1; base_addr = b; base_idx = bi; reg_mask = m;
    pre_step = pre; step_up = up; wb_en = wb;
    @(negedge clk);
    start = 1'b0;
    if (m == 0) begin
      chk(mem_valid == 1'b0 && busy == 1'b0, "R8 no write", {31'd0, mem_valid}, 32'd0);
      chk(done == 1'b1, "R8 done next cycle", {31'd0, done}, 32'd1);
      chk(wb_value == b, "R8 unchanged base", wb_value, b);
      chk(wb_valid == wb, "R4 wb_valid", {31'd0, wb_valid}, {31'd0, wb});
    end else begin
      while (q_idx.size() > 0 && guard < 1000) begin
        int r = q_idx[0];
        bit und = wb && (r == bi) && (r != lowest);
        chk(mem_valid == 1'b1 && busy == 1'b1, "R7 valid while words remain", {31'd0, mem_valid}, 32'd1);
        chk(rf_idx == 4'(r), "R1 register order", {28'd0, rf_idx}, r);
        chk(mem_addr == a, (r == 15) ? "R6 pc slot address" : "R2/R3 address", mem_addr, a);
        chk(mem_wdata == (und ? 32'd0 : rf[r]), "R5 store data", mem_wdata, und ? 32'd0 : rf[r]);
        if (poke && guard == 0) begin
          start = 1'b1; reg_mask = 16'h0001; base_addr = 32'hDEAD_0000; step_up = ~up;
        end
        mem_ready = ($urandom % 4) != 0;
        #1;
        chk(undef_flag == (mem_ready && und), "R5 undef_flag", {31'd0, undef_flag}, {31'd0, mem_ready && und});
        if (mem_ready) begin
          void'(q_idx.pop_front());
          a = a + 4;
        end
        @(negedge clk);
        start = 1'b0;
        guard++;
      end
      mem_ready = 1'b0;
      if (guard >= 1000) chk(1'b0, "R7 transfer stalled", guard, 0);
      chk(done == 1'b1 && mem_valid == 1'b0, "R4 done after last word", {31'd0, done}, 32'd1);
      chk(wb_valid == wb, poke ? "R9 wb_valid" : "R4 wb_valid", {31'd0, wb_valid}, {31'd0, wb});
      chk(wb_value == expwb, poke ? "R9 wb_value" : "R4 wb_value", wb_value, expwb);
      chk(wb_idx == bi, "R4 wb_idx", {28'd0, wb_idx}, {28'd0, bi});
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R4 done one cycle", {31'd0, done}, 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'hA500_0000 + 32'(i * 32'h0111_0001);
    repeat (3) @(negedge clk);
    chk(busy == 0 && mem_valid == 0 && done == 0 && wb_valid == 0 && undef_flag == 0,
        "R10 reset state", {27'd0, busy, mem_valid, done, wb_valid, undef_flag}, 32'd0);
    rst_n = 1'b1;
    run_op(16'h00F0, 32'h0000_1000, 4'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op(16'h8005, 32'h0000_2000, 4'd13, 1'b1, 1'b1, 1'b1, 1'b0);
    run_op(16'h0123, 32'h0000_3000, 4'd12, 1'b0, 1'b0, 1'b1, 1'b0);
    run_op(16'hFFFF, 32'h0000_4000, 4'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    run_op(16'h0014, 32'h0000_5000, 4'd2, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op(16'h0014, 32'h0000_5100, 4'd4, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op(16'h0000, 32'h0000_6000, 4'd6, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op(16'h0C30, 32'h0000_7000, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1);
    run_op(16'h00A5, 32'h0000_8000, 4'd5, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op(16'h8000, 32'h0000_0004, 4'd15, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 12; k++)
      run_op(16'($urandom), 32'h0001_0000 + 32'(k * 256), 4'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 2));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule